// File: doc/BRIEF.md
# Programmable Parallel I/O Port with Strobed Handshake

The block gives a host three byte-wide parallel ports behind a two-bit register address. Ports A and B are full bytes. Port C is split into an upper and a lower nibble, and each nibble has its own direction. One control address takes two kinds of word. A word with bit 7 high sets the mode and direction of every port. A word with bit 7 low writes a single port-C bit and leaves the mode as it is.

In simple mode every port is a plain latched input or output. In strobed mode, ports A and B each take over three port-C lines. One line carries a strobe or acknowledge from the peripheral. One carries the buffer-full flag. One carries an interrupt request. Interrupts are gated by enable flip-flops that software can reach only through single-bit port-C writes.

Pads are not modelled. Each port has separate input, output and output-enable buses. The host bus is synchronous: a read or write is a one-cycle strobe with chip select high. Read data is combinational from the address.

Top module: `pio_hs`

## Requirements
- R1: After reset every port is an input: pa_oe_o, pb_oe_o and all of pc_oe_o are 0, and every output latch is 0.
- R2: The address codes are 0 = port A, 1 = port B, 2 = port C and 3 = control. A read of the control address returns 0.
- R2 (continued): A control write with bit 7 = 1 is a mode word, laid out as follows:
  - bits 6:5 = 01 selects strobed mode for A (any other value selects simple mode);
  - bit 4 = A is an input;
  - bit 3 = upper C nibble is an input;
  - bit 2 = strobed mode for B;
  - bit 1 = B is an input;
  - bit 0 = lower C nibble is an input.
  A mode word also clears all output latches, handshake flags and interrupt enables.
- R3: A control write with bit 7 = 0 writes bit 0 into the port-C latch bit indexed by bits 3:1. It changes no other latch bit and does not change the mode.
- R4: In simple mode, an output port drives its latch and asserts its enable. An input port reads back the live pins. Each port-C nibble follows its own direction bit.
- R5: In strobed mode, the port-C lines are assigned as follows:
  - A as input: PC4 is the active-low strobe in, PC5 is buffer-full out, PC3 is the interrupt out.
  - A as output: PC6 is the active-low acknowledge in, PC7 is the active-low buffer-full out, PC3 is the interrupt out.
  - B, either direction: PC2 is the strobe or acknowledge in, PC1 is the buffer flag out, PC0 is the interrupt out.
  - Port-C lines not used for handshake follow their nibble direction.
- R6: In strobed input, a low strobe sampled at a clock edge latches the port pins and sets buffer-full. A host read of the port returns the latched byte and clears buffer-full.
- R7: In strobed input, the interrupt is set at a clock edge where the strobe is high, buffer-full is 1 and the enable is 1. A host read of the port clears it.
- R8: In strobed output, a host write to the port drives the active-low buffer-full low and clears the interrupt. A low acknowledge returns buffer-full high.
- R9: In strobed output, a rising edge of acknowledge sets the interrupt when buffer-full is inactive (high) and the enable is 1.
- R10: The interrupt enables are written by single-bit port-C words: PC4 for A as input, PC6 for A as output, PC2 for B. With the enable at 0, no interrupt is raised.
- R11: A port-C read returns the driven value on each line whose enable is 1 and the pin value on each line whose enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select for host access |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | One-cycle host write strobe |
| rd_i | input | 1 | One-cycle host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| pa_in_i | input | DW | Port A pins in |
| pa_out_o | output | DW | Port A drive value |
| pa_oe_o | output | 1 | Port A output enable |
| pb_in_i | input | DW | Port B pins in |
| pb_out_o | output | DW | Port B drive value |
| pb_oe_o | output | 1 | Port B output enable |
| pc_in_i | input | 8 | Port C pins in |
| pc_out_o | output | 8 | Port C drive values |
| pc_oe_o | output | 8 | Port C per-line output enables |

## Verification
The bench exercises the following cases:
- A single-bit control word is issued between two mode words. If such a word were taken for a mode word, it would wipe the port directions.
- A mode word is written while data sits in the latches. If the clear were skipped, stale output data would leak out.
- Handshakes are driven on both ports in both directions, with the interrupt enable both on and off. A wrong line map would put the flags on the wrong port-C pins.
- A missing edge detector would raise the output interrupt while acknowledge is still low, or would miss the rising edge altogether.
- A mixed-direction port-C read checks that each line returns either the latch or the pin, according to its own enable.

Randomized simple-mode traffic covers the direction and data combinations.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] ADDR_A   = 2'd0;
  localparam logic [1:0] ADDR_B   = 2'd1;
  localparam logic [1:0] ADDR_C   = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  localparam logic [2:0] INTE_A_IN  = 3'd4;
  localparam logic [2:0] INTE_A_OUT = 3'd6;
  localparam logic [2:0] INTE_B     = 3'd2;

  typedef struct packed {
    logic a_m1;
    logic a_in;
    logic cu_in;
    logic b_m1;
    logic b_in;
    logic cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{a_m1: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                     b_m1: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pio_cfg_t decode_mode(input logic [7:0] w);
    pio_cfg_t c;
    c.a_m1  = (w[6:5] == 2'b01);
    c.a_in  = w[4];
    c.cu_in = w[3];
    c.b_m1  = w[2];
    c.b_in  = w[1];
    c.cl_in = w[0];
    return c;
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cw_we_i,
  input  logic       pc_we_i,
  input  logic [7:0] wdata_i,
  output pio_cfg_t   cfg_o,
  output logic [7:0] pc_q_o,
  output logic       inte_a_o,
  output logic       inte_b_o,
  output logic       mode_wr_o
);
  pio_cfg_t   cfg_q;
  logic [7:0] pc_q;
  logic       inte_a_q, inte_b_q;
  logic [2:0] bit_idx;
  logic       bit_val;

  assign mode_wr_o = cw_we_i & wdata_i[7];
  assign bit_idx   = wdata_i[3:1];
  assign bit_val   = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RESET;
      pc_q     <= '0;
      inte_a_q <= 1'b0;
      inte_b_q <= 1'b0;
    end else if (mode_wr_o) begin
      cfg_q    <= decode_mode(wdata_i);
      pc_q     <= '0;
      inte_a_q <= 1'b0;
      inte_b_q <= 1'b0;
    end else if (cw_we_i) begin
      pc_q[bit_idx] <= bit_val;
      if (cfg_q.a_m1 && bit_idx == (cfg_q.a_in ? INTE_A_IN : INTE_A_OUT))
        inte_a_q <= bit_val;
      if (cfg_q.b_m1 && bit_idx == INTE_B)
        inte_b_q <= bit_val;
    end else if (pc_we_i) begin
      pc_q <= wdata_i;
    end
  end

  assign cfg_o    = cfg_q;
  assign pc_q_o   = pc_q;
  assign inte_a_o = inte_a_q;
  assign inte_b_o = inte_b_q;

  // R3: single-bit word keeps mode
  a_r3_bsr_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i && !wdata_i[7] |=> $stable(cfg_q));
  // R2: mode word clears port-C latch and enables
  a_r2_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_o |=> (pc_q == 8'h00) && !inte_a_q && !inte_b_q);
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic          mode1_i,
  input  logic          dir_in_i,
  input  logic          inte_i,
  input  logic          hs_n_i,
  input  logic [DW-1:0] pin_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] out_o,
  output logic          oe_o,
  output logic          bf_o,
  output logic          intr_o
);
  logic [DW-1:0] out_q, in_q;
  logic          ibf_q, obf_n_q, intr_q, hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      in_q    <= '0;
      ibf_q   <= 1'b0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
      hs_q    <= 1'b1;
    end else begin
      hs_q <= hs_n_i;
      if (mode_wr_i) begin
        out_q   <= '0;
        in_q    <= '0;
        ibf_q   <= 1'b0;
        obf_n_q <= 1'b1;
        intr_q  <= 1'b0;
      end else begin
        if (host_wr_i) out_q <= wdata_i;
        if (mode1_i && dir_in_i) begin
          if (!hs_n_i) begin
            in_q  <= pin_i;
            ibf_q <= 1'b1;
          end else if (host_rd_i) begin
            ibf_q <= 1'b0;
          end
          if (host_rd_i) intr_q <= 1'b0;
          else if (hs_n_i && ibf_q && inte_i) intr_q <= 1'b1;
        end else if (mode1_i) begin
          if (host_wr_i) begin
            obf_n_q <= 1'b0;
            intr_q  <= 1'b0;
          end else begin
            if (!hs_n_i) obf_n_q <= 1'b1;
            // rising acknowledge edge
            if (!hs_q && hs_n_i && obf_n_q && inte_i) intr_q <= 1'b1;
          end
        end
      end
    end
  end

  assign out_o   = out_q;
  assign oe_o    = !dir_in_i;
  assign bf_o    = dir_in_i ? ibf_q : obf_n_q;
  assign intr_o  = intr_q;
  assign rdata_o = !dir_in_i ? out_q : (mode1_i ? in_q : pin_i);

  a_r6_strobe_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode1_i && dir_in_i && !hs_n_i && !mode_wr_i |=> bf_o);
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode1_i && dir_in_i && hs_n_i && host_rd_i && !mode_wr_i |=> !bf_o && !intr_o);
  a_r8_write_marks_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode1_i && !dir_in_i && host_wr_i && !mode_wr_i |=> !bf_o && !intr_o);
  a_r9_ack_rise_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode1_i && !dir_in_i && !hs_q && hs_n_i && obf_n_q && inte_i
      && !host_wr_i && !mode_wr_i |=> intr_o);
  a_r10_no_irq_simple: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode1_i && !intr_o |=> !intr_o || $past(mode1_i));
endmodule

// File: rtl/pio_hs.sv
module pio_hs
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [DW-1:0] pa_in_i,
  output logic [DW-1:0] pa_out_o,
  output logic          pa_oe_o,
  input  logic [DW-1:0] pb_in_i,
  output logic [DW-1:0] pb_out_o,
  output logic          pb_oe_o,
  input  logic [7:0]    pc_in_i,
  output logic [7:0]    pc_out_o,
  output logic [7:0]    pc_oe_o
);
  localparam int NP = 2;

  logic          acc_wr, acc_rd, cw_we, pc_we, mode_wr, inte_a, inte_b;
  pio_cfg_t      cfg;
  logic [7:0]    pc_q, hs_own, hs_oe, hs_val, half_oe;
  logic [NP-1:0] p_m1, p_din, p_inte, p_hsn, p_we, p_re, p_oe, p_bf, p_intr;
  logic [DW-1:0] p_pin [NP];
  logic [DW-1:0] p_out [NP];
  logic [DW-1:0] p_rd  [NP];

  assign acc_wr = sel_i & wr_i;
  assign acc_rd = sel_i & rd_i;
  assign cw_we  = acc_wr && (addr_i == ADDR_CTL);
  assign pc_we  = acc_wr && (addr_i == ADDR_C);

  pio_ctrl u_ctrl (
    .clk_i, .rst_ni, .cw_we_i(cw_we), .pc_we_i(pc_we), .wdata_i,
    .cfg_o(cfg), .pc_q_o(pc_q), .inte_a_o(inte_a), .inte_b_o(inte_b),
    .mode_wr_o(mode_wr)
  );

  assign p_m1   = {cfg.b_m1, cfg.a_m1};
  assign p_din  = {cfg.b_in, cfg.a_in};
  assign p_inte = {inte_b, inte_a};
  assign p_hsn  = {pc_in_i[2], cfg.a_in ? pc_in_i[4] : pc_in_i[6]};
  assign p_pin[0] = pa_in_i;
  assign p_pin[1] = pb_in_i;

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign p_we[g] = acc_wr && (addr_i == 2'(g));
    assign p_re[g] = acc_rd && (addr_i == 2'(g));
    pio_port #(.DW(DW)) u_port (
      .clk_i, .rst_ni, .mode_wr_i(mode_wr), .mode1_i(p_m1[g]),
      .dir_in_i(p_din[g]), .inte_i(p_inte[g]), .hs_n_i(p_hsn[g]),
      .pin_i(p_pin[g]), .host_wr_i(p_we[g]), .host_rd_i(p_re[g]),
      .wdata_i(wdata_i[DW-1:0]), .rdata_o(p_rd[g]), .out_o(p_out[g]),
      .oe_o(p_oe[g]), .bf_o(p_bf[g]), .intr_o(p_intr[g])
    );
  end

  // handshake line map on port C
  always_comb begin
    hs_own = '0;
    hs_oe  = '0;
    hs_val = '0;
    if (cfg.a_m1) begin
      hs_own[3] = 1'b1; hs_oe[3] = 1'b1; hs_val[3] = p_intr[0];
      if (cfg.a_in) begin
        hs_own[5:4] = 2'b11; hs_oe[5] = 1'b1; hs_val[5] = p_bf[0];
      end else begin
        hs_own[7:6] = 2'b11; hs_oe[7] = 1'b1; hs_val[7] = p_bf[0];
      end
    end
    if (cfg.b_m1) begin
      hs_own[2:0] = 3'b111;
      hs_oe[1:0]  = 2'b11;
      hs_val[1:0] = {p_bf[1], p_intr[1]};
    end
  end

  assign half_oe  = {{4{!cfg.cu_in}}, {4{!cfg.cl_in}}};
  assign pc_oe_o  = (hs_own & hs_oe) | (~hs_own & half_oe);
  assign pc_out_o = (hs_own & hs_val) | (~hs_own & pc_q);

  assign pa_out_o = p_out[0];
  assign pb_out_o = p_out[1];
  assign pa_oe_o  = p_oe[0];
  assign pb_oe_o  = p_oe[1];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_A:  rdata_o[DW-1:0] = p_rd[0];
      ADDR_B:  rdata_o[DW-1:0] = p_rd[1];
      ADDR_C:  rdata_o = (pc_oe_o & pc_out_o) | (~pc_oe_o & pc_in_i);
      default: rdata_o = '0;
    endcase
  end

  // R5: strobe/ack lines of a strobed port are never driven
  a_r5_hs_inputs_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.b_m1 |-> !pc_oe_o[2]);
endmodule

// File: tb/pio_hs_tb_top.sv
module pio_hs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_i = 0, wr_i = 0, rd_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic [DW-1:0] pa_in_i = 0, pa_out_o, pb_in_i = 0, pb_out_o;
  logic pa_oe_o, pb_oe_o;
  logic [7:0] pc_in_i = 0, pc_out_o, pc_oe_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] rd_v;
  logic m_ain, m_bin, m_cu, m_cl;
  logic [7:0] m_pa, m_pb, m_pc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pio_hs #(.DW(DW)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0;
    #1;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; rd_i = 1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 0; rd_i = 0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  function automatic logic [7:0] exp_pc_oe();
    return {{4{!m_cu}}, {4{!m_cl}}};
  endfunction

  function automatic logic [7:0] exp_pc_rd(input logic [7:0] oe, input logic [7:0] pin);
    return (oe & m_pc) | (~oe & pin);
  endfunction

  task automatic mode0_word(input logic [7:0] w);
    host_wr(2'd3, w);
    m_ain = w[4]; m_cu = w[3]; m_bin = w[1]; m_cl = w[0];
    m_pa = 0; m_pb = 0; m_pc = 0;
  endtask

  task automatic chk_mode0(input string tag);
    chk({tag, " pa_oe"}, pa_oe_o, !m_ain);
    chk({tag, " pb_oe"}, pb_oe_o, !m_bin);
    chk({tag, " pc_oe"}, pc_oe_o, exp_pc_oe());
    chk({tag, " pa_out"}, pa_out_o, m_pa);
    chk({tag, " pb_out"}, pb_out_o, m_pb);
    chk({tag, " pc_out"}, pc_out_o, m_pc);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 pa_oe", pa_oe_o, 0);
    chk("R1 pb_oe", pb_oe_o, 0);
    chk("R1 pc_oe", pc_oe_o, 0);
    chk("R1 pa_out", pa_out_o, 0);
    host_rd(2'd3, rd_v);
    chk("R2 ctl read", rd_v, 8'h00);

    // R4 simple mode, all outputs
    mode0_word(8'h80);
    host_wr(2'd0, 8'h5A); m_pa = 8'h5A;
    chk("R4 pa_out", pa_out_o, 8'h5A);
    chk("R4 pa_oe", pa_oe_o, 1);
    host_rd(2'd0, rd_v);
    chk("R4 read A out", rd_v, 8'h5A);
    host_wr(2'd2, 8'hC3);
    chk("R4 pc_out", pc_out_o, 8'hC3);
    chk("R4 pc_oe", pc_oe_o, 8'hFF);
    // R3 single-bit words
    host_wr(2'd3, 8'h05);
    chk("R3 set bit2", pc_out_o, 8'hC7);
    chk("R3 mode kept", {pa_oe_o, pb_oe_o, pc_oe_o}, {2'b11, 8'hFF});
    host_wr(2'd3, 8'h0E);
    chk("R3 clr bit7", pc_out_o, 8'h47);
    // R2 mode word clears latches
    mode0_word(8'h89);
    chk("R2 pa cleared", pa_out_o, 0);
    chk("R2 pc_oe", pc_oe_o, 8'h00);
    pc_in_i = 8'hA5;
    host_rd(2'd2, rd_v);
    chk("R11 pc all in", rd_v, 8'hA5);
    mode0_word(8'h88);
    host_wr(2'd2, 8'hFF); m_pc = 8'hFF;
    chk("R4 halves oe", pc_oe_o, 8'h0F);
    pc_in_i = 8'h30;
    host_rd(2'd2, rd_v);
    chk("R11 pc mixed", rd_v, 8'h3F);

    // strobed: A input, B output, nibbles out
    pc_in_i = 8'hFF;
    host_wr(2'd3, 8'hB4);
    chk("R5 pc_oe A in B out", pc_oe_o, 8'hEB);
    chk("R5 pc_out idle", pc_out_o, 8'h02);
    host_wr(2'd3, 8'h09);
    host_wr(2'd3, 8'h05);
    pa_in_i = 8'h3C; pc_in_i[4] = 0;
    tick();
    chk("R6 ibf set", pc_out_o[5], 1);
    chk("R7 no irq while strobe low", pc_out_o[3], 0);
    pc_in_i[4] = 1; pa_in_i = 8'h00;
    tick();
    chk("R7 irq set", pc_out_o[3], 1);
    host_rd(2'd0, rd_v);
    chk("R6 latched data", rd_v, 8'h3C);
    chk("R6 ibf cleared", pc_out_o[5], 0);
    chk("R7 irq cleared", pc_out_o[3], 0);
    host_wr(2'd3, 8'h08);
    pa_in_i = 8'h81; pc_in_i[4] = 0;
    tick();
    pc_in_i[4] = 1;
    tick(); tick();
    chk("R10 ibf with enable off", pc_out_o[5], 1);
    chk("R10 no irq enable off", pc_out_o[3], 0);
    host_rd(2'd0, rd_v);
    chk("R6 second byte", rd_v, 8'h81);
    // port B output
    host_wr(2'd1, 8'h77);
    chk("R8 pb_out", pb_out_o, 8'h77);
    chk("R8 obf low", pc_out_o[1], 0);
    pc_in_i[2] = 0;
    tick();
    chk("R8 ack returns obf", pc_out_o[1], 1);
    chk("R9 no irq while ack low", pc_out_o[0], 0);
    pc_in_i[2] = 1;
    tick();
    chk("R9 irq on ack rise", pc_out_o[0], 1);
    host_wr(2'd1, 8'h11);
    chk("R8 write clears irq", pc_out_o[0], 0);
    chk("R8 obf low again", pc_out_o[1], 0);
    host_rd(2'd2, rd_v);
    chk("R11 pc strobed read", rd_v, 8'h14);

    // strobed: A output, B simple input
    host_wr(2'd3, 8'hAB);
    chk("R5 pc_oe A out", pc_oe_o, 8'h88);
    chk("R5 pc_out A out", pc_out_o, 8'h80);
    host_wr(2'd3, 8'h0D);
    host_wr(2'd0, 8'h99);
    chk("R8 A obf low", pc_out_o[7], 0);
    pc_in_i[6] = 0;
    tick();
    pc_in_i[6] = 1;
    tick();
    chk("R10 A irq via PC6 enable", pc_out_o[3], 1);
    chk("R9 A obf high", pc_out_o[7], 1);
    pb_in_i = 8'h42;
    host_rd(2'd1, rd_v);
    chk("R4 B simple input", rd_v, 8'h42);

    // randomized simple-mode traffic
    mode0_word(8'h80);
    for (int i = 0; i < 60; i++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: mode0_word({1'b1, 2'b00, 1'($urandom), 1'($urandom), 1'b0,
                       1'($urandom), 1'($urandom)});
        1: begin
          logic [7:0] d;
          int p;
          d = 8'($urandom);
          p = int'($urandom % 3);
          host_wr(2'(p), d);
          if (p == 0) m_pa = d; else if (p == 1) m_pb = d; else m_pc = d;
        end
        2: begin
          logic [2:0] ix;
          logic v;
          ix = 3'($urandom); v = 1'($urandom);
          host_wr(2'd3, {4'b0, ix, v});
          m_pc[ix] = v;
        end
        default: begin
          int p;
          p = int'($urandom % 3);
          pa_in_i = 8'($urandom); pb_in_i = 8'($urandom); pc_in_i = 8'($urandom);
          host_rd(2'(p), rd_v);
          if (p == 0) chk("R4 rnd read A", rd_v, m_ain ? pa_in_i : m_pa);
          else if (p == 1) chk("R4 rnd read B", rd_v, m_bin ? pb_in_i : m_pb);
          else chk("R11 rnd read C", rd_v, exp_pc_rd(exp_pc_oe(), pc_in_i));
        end
      endcase
      chk_mode0("R4 rnd");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule